// File: doc/BRIEF.md
# Three-Channel Interval Timer Bus Front End

This block is the byte-wide register interface that sits between a host bus and three interval-timer channels. A 2-bit address picks one of three data ports (0, 1, 2) or the control port (3). Control writes program each channel's byte-access pattern, counting mode and BCD flag. They also issue snapshot commands, either for a single channel's count or, through a read-back command, for the count and status of several channels at once.

Data-port writes are assembled into 16-bit counts. Each finished count goes to its channel as a one-cycle load strobe with the value. Data-port reads return a status snapshot first, then a count snapshot, and otherwise the channel's live count. The reads are sequenced byte by byte according to the channel's access pattern. The counting logic is outside this block: each channel supplies its live count and its output level, and receives its mode and BCD flag.

Read data is combinational from registered state and is valid in the cycle `rd_en` is high. The read's side effects (advancing sequencers, releasing snapshots) take place at the clock edge that ends that cycle.

Top module: `tmr_bus_frontend`

## Requirements
- R1: A control write (address 3) whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are nonzero sets that channel's access pattern from bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high), its mode from bits 3:1 and its BCD flag from bit 0. The new mode and flag appear on `ch_mode`/`ch_bcd` from the next cycle.
- R2: A control write naming a channel with bits 5:4 equal to 0 snapshots that channel's live count. Later changes of the live count do not alter the bytes read from the snapshot.
- R3: A count or status snapshot request for a channel that still holds an unread snapshot of the same kind is ignored.
- R4: A control write with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low snapshots the count and bit 4 low snapshots the status of every selected channel. Channels that are not selected are left untouched.
- R5: The status byte is {out level in bit 7, 0 in bit 6, access pattern in bits 5:4, mode in bits 3:1, BCD in bit 0}, captured when the status snapshot is taken.
- R6: A data-port read returns a pending status snapshot first. If there is none it returns a pending count snapshot, and otherwise the live count. Reading the status leaves a pending count snapshot in place.
- R7: A count snapshot is read out as the access pattern in force when it was taken gives: the low byte alone, the high byte alone, or the low byte and then the high byte. The snapshot is released after its last byte, and reads then return the live count again.
- R8: In low-only mode a data write loads {8'h00, byte}. In high-only mode it loads {byte, 8'h00}. In low-then-high mode the first write is held and the second loads {second, first}. The load strobe for that channel pulses for one cycle, with the value, in the cycle after the completing write.
- R9: With no snapshot pending, live-count reads in low-then-high mode alternate between the low and high byte, starting with the low byte.
- R10: A control write that sets the access pattern returns both the read and the write byte sequencers of that channel to their first byte.
- R11: After reset every channel is in low-then-high mode with mode 0, BCD 0, no pending snapshot, both sequencers at the first byte and no load strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port select: 0..2 data, 3 control |
| wr_en | input | 1 | Write strobe for `wdata` |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; side effects at the end of the cycle |
| rdata | output | 8 | Read byte, valid while `rd_en` is high |
| live_cnt | input | 48 | Live count of each channel, channel i in bits 16i+15:16i |
| ch_out | input | 3 | Output level of each channel |
| load_stb | output | 3 | One-cycle count-load strobe per channel |
| load_val | output | 48 | Count value per channel, channel i in bits 16i+15:16i |
| ch_mode | output | 9 | Mode of each channel, channel i in bits 3i+2:3i |
| ch_bcd | output | 3 | BCD flag of each channel |

## Verification
The bench programs each channel into a different access pattern and drives single writes, byte pairs, and pairs cut short by reprogramming. This tells a correct load from a byte-order or sequencer-reset error. Snapshots are taken, the live count is then changed before reading, and a second request is issued on a pending snapshot. A stale or a re-captured value is therefore visible at the data port. Read-back commands that mix count and status over a subset of channels check the status bit layout, the status-before-count ordering and the release back to live reads, and show that unselected channels are left alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e                acc;
        logic [MODE_W-1:0]   mode;
        logic                bcd;
        logic                wr_hi;
        logic [BYTE_W-1:0]   wr_hold;
        logic                rd_hi;
        logic                cnt_vld;
        acc_e                cnt_acc;
        logic                cnt_hi;
        logic [CNT_W-1:0]    cnt_snap;
        logic                sts_vld;
        logic [BYTE_W-1:0]   sts_snap;
        logic                load_stb;
        logic [CNT_W-1:0]    load_val;
    } chan_st_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [N_CH-1:0]   cfg_we,
    output logic [N_CH-1:0]   cnt_req,
    output logic [N_CH-1:0]   sts_req,
    output logic [N_CH-1:0]   data_we,
    output logic [N_CH-1:0]   data_re
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;
    localparam logic [1:0] RB_SEL    = 2'd3;

    always_comb begin
        cfg_we  = '0;
        cnt_req = '0;
        sts_req = '0;
        data_we = '0;
        data_re = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (rd_en && addr == 2'(i)) data_re[i] = 1'b1;
            if (wr_en && addr == 2'(i)) data_we[i] = 1'b1;
            if (wr_en && addr == CTRL_ADDR) begin
                if (wdata[7:6] == RB_SEL) begin
                    if (wdata[i+1]) begin
                        cnt_req[i] = ~wdata[5];
                        sts_req[i] = ~wdata[4];
                    end
                end else if (wdata[7:6] == 2'(i)) begin
                    if (wdata[5:4] == ACC_LATCH) cnt_req[i] = 1'b1;
                    else                         cfg_we[i]  = 1'b1;
                end
            end
        end
    end

    // R8
    data_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_we));
    // R4
    cfg_vs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we & (cnt_req | sts_req)) == '0);
    // R1
    ctrl_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cfg_we | cnt_req | sts_req)) |-> (data_we == '0));
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cnt_req,
    input  logic              sts_req,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode,
    output logic              bcd
);
    chan_st_t st_d, st_q;

    function automatic logic [BYTE_W-1:0] pick(input logic [CNT_W-1:0] v, input logic hi);
        return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

    always_comb begin
        st_d          = st_q;
        st_d.load_stb = 1'b0;

        // read data, priority status > count snapshot > live
        if (st_q.sts_vld)      rd_byte = st_q.sts_snap;
        else if (st_q.cnt_vld) rd_byte = pick(st_q.cnt_snap, st_q.cnt_hi);
        else begin
            case (st_q.acc)
                ACC_HI:   rd_byte = pick(live_cnt, 1'b1);
                ACC_WORD: rd_byte = pick(live_cnt, st_q.rd_hi);
                default:  rd_byte = pick(live_cnt, 1'b0);
            endcase
        end

        if (data_re) begin
            if (st_q.sts_vld) begin
                st_d.sts_vld = 1'b0;
            end else if (st_q.cnt_vld) begin
                if (st_q.cnt_acc == ACC_WORD && !st_q.cnt_hi) st_d.cnt_hi  = 1'b1;
                else                                          st_d.cnt_vld = 1'b0;
            end else if (st_q.acc == ACC_WORD) begin
                st_d.rd_hi = ~st_q.rd_hi;
            end
        end

        if (cnt_req && !st_q.cnt_vld) begin
            st_d.cnt_vld  = 1'b1;
            st_d.cnt_snap = live_cnt;
            st_d.cnt_acc  = st_q.acc;
            st_d.cnt_hi   = (st_q.acc == ACC_HI);
        end

        if (sts_req && !st_q.sts_vld) begin
            st_d.sts_vld  = 1'b1;
            st_d.sts_snap = {out_lvl, 1'b0, st_q.acc, st_q.mode, st_q.bcd};
        end

        if (cfg_we) begin
            st_d.acc   = acc_e'(wdata[5:4]);
            st_d.mode  = wdata[3:1];
            st_d.bcd   = wdata[0];
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
        end

        if (data_we) begin
            case (st_q.acc)
                ACC_HI: begin
                    st_d.load_stb = 1'b1;
                    st_d.load_val = {wdata, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    if (!st_q.wr_hi) begin
                        st_d.wr_hold = wdata;
                        st_d.wr_hi   = 1'b1;
                    end else begin
                        st_d.load_stb = 1'b1;
                        st_d.load_val = {wdata, st_q.wr_hold};
                        st_d.wr_hi    = 1'b0;
                    end
                end
                default: begin
                    st_d.load_stb = 1'b1;
                    st_d.load_val = {{BYTE_W{1'b0}}, wdata};
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.acc <= ACC_WORD;
            st_q.cnt_acc <= ACC_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_stb = st_q.load_stb;
    assign load_val = st_q.load_val;
    assign mode     = st_q.mode;
    assign bcd      = st_q.bcd;

    // R8
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && st_q.acc == ACC_LO) |=> (load_stb && load_val[CNT_W-1:BYTE_W] == '0));
    // R8
    stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> $past(data_we));
    // R10
    seq_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!st_q.wr_hi && !st_q.rd_hi));
    // R3
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts_vld && !data_re) |=> $stable(st_q.sts_snap));
    // R6
    cnt_survives_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts_vld && st_q.cnt_vld && data_re) |=> st_q.cnt_vld);
endmodule

// File: rtl/tmr_bus_frontend.sv
module tmr_bus_frontend
    import tmr_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              addr,
    input  logic                    wr_en,
    input  logic [BYTE_W-1:0]       wdata,
    input  logic                    rd_en,
    output logic [BYTE_W-1:0]       rdata,
    input  logic [N_CH*CNT_W-1:0]   live_cnt,
    input  logic [N_CH-1:0]         ch_out,
    output logic [N_CH-1:0]         load_stb,
    output logic [N_CH*CNT_W-1:0]   load_val,
    output logic [N_CH*MODE_W-1:0]  ch_mode,
    output logic [N_CH-1:0]         ch_bcd
);
    logic [N_CH-1:0]   cfg_we, cnt_req, sts_req, data_we, data_re;
    logic [BYTE_W-1:0] rd_bytes [N_CH];

    tmr_cmd_decode #(.N_CH(N_CH)) i_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .cfg_we  (cfg_we),
        .cnt_req (cnt_req),
        .sts_req (sts_req),
        .data_we (data_we),
        .data_re (data_re)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        tmr_chan_regs i_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[g]),
            .cnt_req  (cnt_req[g]),
            .sts_req  (sts_req[g]),
            .data_we  (data_we[g]),
            .data_re  (data_re[g]),
            .wdata    (wdata),
            .live_cnt (live_cnt[g*CNT_W +: CNT_W]),
            .out_lvl  (ch_out[g]),
            .rd_byte  (rd_bytes[g]),
            .load_stb (load_stb[g]),
            .load_val (load_val[g*CNT_W +: CNT_W]),
            .mode     (ch_mode[g*MODE_W +: MODE_W]),
            .bcd      (ch_bcd[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_CH; i++)
            if (rd_en && addr == 2'(i)) rdata = rd_bytes[i];
    end

    // R11
    no_stb_after_rst_chk: assert property (@(posedge clk)
        !rst_n |=> (load_stb == '0));
endmodule

// File: tb/test_tmr_bus_frontend.sv
`timescale 1ns/1ps
module test_tmr_bus_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] live_cnt = '0;
    logic [2:0]  ch_out = '0;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [7:0]  rd_q [$];
    string       rd_tag_q [$];
    logic [17:0] ld_q [$];
    string       ld_tag_q [$];

    always #2 clk = ~clk;

    tmr_bus_frontend i_tmr_bus_frontend (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .live_cnt(live_cnt), .ch_out(ch_out),
        .load_stb(load_stb), .load_val(load_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        rd_q.push_back(exp);
        rd_tag_q.push_back(tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic exp_load(input int ch, input logic [15:0] v, input string tag);
        ld_q.push_back({2'(ch), v});
        ld_tag_q.push_back(tag);
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        live_cnt[ch*16 +: 16] = v;
    endtask

    // monitor
    always begin
        @(negedge clk);
        #1;
        if (rst_n && rd_en) begin
            if (rd_q.size() == 0) check("unexpected read", 32'(rdata), 32'hFFFF_FFFF);
            else check(rd_tag_q.pop_front(), 32'(rdata), 32'(rd_q.pop_front()));
        end
        if (rst_n) begin
            for (int c = 0; c < 3; c++) begin
                if (load_stb[c]) begin
                    if (ld_q.size() == 0)
                        check("R8 unexpected load", {14'(c), load_val[c*16 +: 16]}, 32'hFFFF_FFFF);
                    else
                        check(ld_tag_q.pop_front(), {14'(c), load_val[c*16 +: 16]}, 32'(ld_q.pop_front()));
                end
            end
        end
    end

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 load_stb", 32'(load_stb), 0);
        check("R11 ch_mode", 32'(ch_mode), 0);
        check("R11 ch_bcd", 32'(ch_bcd), 0);
        set_live(0, 16'h1234);
        bus_rd(0, 8'h34, "R11 word default lo");
        bus_rd(0, 8'h12, "R11 word default hi");

        // R1 / R8 low-only
        bus_wr(3, 8'h14);
        check("R1 ch0 mode", 32'(ch_mode[2:0]), 2);
        exp_load(0, 16'h0055, "R8 lo load");
        bus_wr(0, 8'h55);
        // high-only, mode 3, bcd
        bus_wr(3, 8'h67);
        check("R1 ch1 mode", 32'(ch_mode[5:3]), 3);
        check("R1 ch1 bcd", 32'(ch_bcd[1]), 1);
        exp_load(1, 16'hAB00, "R8 hi load");
        bus_wr(1, 8'hAB);
        // word
        bus_wr(3, 8'hB0);
        bus_wr(2, 8'h11);
        exp_load(2, 16'h2211, "R8 word load");
        bus_wr(2, 8'h22);

        // R9 live alternation
        set_live(2, 16'hBEEF);
        bus_rd(2, 8'hEF, "R9 lo");
        bus_rd(2, 8'hBE, "R9 hi");
        bus_rd(2, 8'hEF, "R9 lo again");

        // R10 sequencer restart
        bus_wr(3, 8'hB0);
        bus_rd(2, 8'hEF, "R10 read restarts lo");
        bus_wr(2, 8'h33);
        bus_wr(3, 8'hB0);
        bus_wr(2, 8'h44);
        exp_load(2, 16'h5544, "R10 write restarts");
        bus_wr(2, 8'h55);

        // R2 / R7 word snapshot
        bus_wr(3, 8'hB0);
        set_live(2, 16'h1357);
        bus_wr(3, 8'h80);
        set_live(2, 16'h2468);
        bus_rd(2, 8'h57, "R2 snap lo");
        bus_rd(2, 8'h13, "R7 snap hi");
        bus_rd(2, 8'h68, "R7 released to live");

        // R3 repeated count latch ignored (ch0 low-only)
        set_live(0, 16'h00AA);
        bus_wr(3, 8'h00);
        set_live(0, 16'h00BB);
        bus_wr(3, 8'h00);
        bus_rd(0, 8'hAA, "R3 first snapshot kept");
        bus_rd(0, 8'hBB, "R7 lo snapshot released");

        // R7 high-only snapshot
        set_live(1, 16'h9A01);
        bus_wr(3, 8'h40);
        set_live(1, 16'h7700);
        bus_rd(1, 8'h9A, "R7 hi snapshot");
        bus_rd(1, 8'h77, "R7 hi released");

        // R4 / R5 / R6 read-back count+status ch0, ch1
        set_live(0, 16'h0042);
        set_live(1, 16'h5500);
        ch_out = 3'b001;
        bus_wr(3, 8'hC6);
        set_live(0, 16'h0000);
        set_live(1, 16'h0000);
        ch_out = 3'b000;
        bus_rd(0, 8'h94, "R5 status ch0");
        bus_rd(0, 8'h42, "R6 count after status");
        bus_rd(0, 8'h00, "R6 live last");
        bus_rd(1, 8'h27, "R5 status ch1");
        bus_rd(1, 8'h55, "R4 count ch1");
        bus_rd(1, 8'h00, "R6 live ch1");

        // R3 / R4 status-only read-back of ch2
        ch_out = 3'b100;
        set_live(0, 16'h0077);
        bus_wr(3, 8'hE8);
        ch_out = 3'b000;
        bus_wr(3, 8'hE8);
        set_live(2, 16'h0C0D);
        bus_rd(2, 8'hB0, "R3 status kept");
        bus_rd(2, 8'h0C, "R4 no count latched");
        bus_rd(0, 8'h77, "R4 unselected ch0 live");

        repeat (4) @(negedge clk);
        check("R8 pending loads", 32'(ld_q.size()), 0);
        check("R6 pending reads", 32'(rd_q.size()), 0);
        summary();
    end
endmodule